// File: doc/BRIEF.md
# Output Reference Slew Controller

This block produces the regulation reference for a step-down converter as a fixed-point value relative to the nominal setpoint. Two codes set the reference. A 5-bit trim code gives a fine adjustment of up to ±9%. A 3-bit margin code gives a coarse shift of ±5% or ±10%. The block multiplies the two percentage factors to form a target.

While the converter is switching, a change to either code does not move the reference at once. The reference walks toward the new target, one bounded step per timebase tick. For the whole walk, and for a settling window after it, the block asserts a fault-blanking output and forces discontinuous-mode operation. An optional output pull-down helps the output follow a downward walk. The settling window ends after a fixed number of switching cycles. If the converter is not switching often enough, it ends after a timeout counted in ticks.

While the converter is not switching, the reference follows the codes directly and the block asserts none of its control outputs.

Top module: `ref_slew_ctrl`

## Requirements
- R1: Trim code decode, in units of 0.01%. Codes 0 to 3 give -900. Codes 4 to 15 give (code-15)*75, so code 4 gives -825 and code 15 gives 0. Codes 16 to 27 give (code-16)*75, so code 16 gives 0 and code 17 gives +75. Codes 28 to 31 give +900.
- R2: Margin code decode, in units of 0.01%. Code 1 gives -1000. Code 2 gives -500. Code 5 gives +500. Code 6 gives +1000. Codes 0, 3, 4 and 7 give 0.
- R3: The reference is an unsigned value in units of 0.01% of nominal, where nominal is 10000. The target is (10000+margin)*(10000+trim)/10000, rounded down.
- R4: While `running` is low, `ref_level` equals the target one clock after the codes are applied. `blank`, `force_dcm` and `pulldown_en` stay low.
- R5: While `running` is high, a change of either code raises `blank` on the next clock.
- R6: In a slew, each `tick` pulse moves `ref_level` toward the target by 75, or by the remaining distance if that is smaller. The reference never passes the target, and it does not move between ticks.
- R7: After the reference reaches the target, `blank` falls on the clock of the 8th `sw_cycle` pulse. Pulses that arrive during the walk do not count.
- R8: If fewer than 8 `sw_cycle` pulses arrive after the reference reaches the target, `blank` falls on the 31st `tick` pulse.
- R9: `force_dcm` equals `blank` on every cycle.
- R10: `pulldown_en` is high only while a slew is stepping downward (target below reference) and `intload_en` is high. It stays low on upward slews and during the settling window.
- R11: A code change during a slew or during the settling window retargets the walk from the current reference. It also restarts the settling count from zero.
- R12: When `running` falls, on the next clock `ref_level` takes the target and `blank` is low.
- R13: After reset, `ref_level` is 10000 and `blank`, `force_dcm` and `pulldown_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trim_code | input | 5 | Fine-adjust code |
| margin_code | input | 3 | Margin code |
| intload_en | input | 1 | Allows the output pull-down on downward slews |
| sw_cycle | input | 1 | One-clock pulse per converter switching cycle |
| tick | input | 1 | One-clock timebase pulse, one per slew step period |
| running | input | 1 | High while the converter is switching |
| ref_level | output | 14 | Active reference, 0.01% units, 10000 = nominal |
| blank | output | 1 | Fault blanking |
| force_dcm | output | 1 | Forces discontinuous-mode operation |
| pulldown_en | output | 1 | Enables the output pull-down |

## Verification
On every cycle, the assertions check that the reference moves by at most one step, that it never passes the target, and that the pull-down is raised only for a downward walk with the internal load allowed. They also check that blanking clears one clock after `running` falls, and that the settling window ends only from the settling state. The bench scenarios cover the rest: the decoded target values, the exact tick on which each step lands, the release of blanking on the 8th switching pulse or the 31st tick, and the restart of the window when a code changes mid-slew.

// File: rtl/ref_slew_pkg.sv
package ref_slew_pkg;
    localparam int TRIM_W   = 5;
    localparam int MARGIN_W = 3;
    localparam int REF_W    = 14;
    localparam int NOMINAL  = 10000;
    localparam int TRIM_LSB = 75;
    localparam logic [TRIM_W-1:0]   TRIM_ZERO   = TRIM_W'(1 << (TRIM_W - 1));
    localparam logic [MARGIN_W-1:0] MARGIN_ZERO = '0;

    typedef logic [REF_W-1:0] ref_t;

    typedef enum logic [1:0] {
        BL_IDLE,
        BL_SLEW,
        BL_SETTLE
    } blank_state_e;

    function automatic int trim_offset(input logic [TRIM_W-1:0] code);
        int c;
        c = int'(code);
        if (c <= 3)       return -900;
        else if (c >= 28) return 900;
        else if (c >= 16) return (c - 16) * TRIM_LSB;
        else              return (c - 15) * TRIM_LSB;
    endfunction

    function automatic int margin_offset(input logic [MARGIN_W-1:0] code);
        case (code)
            3'd1:    return -1000;
            3'd2:    return -500;
            3'd5:    return 500;
            3'd6:    return 1000;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/ref_target_calc.sv
module ref_target_calc
    import ref_slew_pkg::*;
(
    input  logic [TRIM_W-1:0]   trim_code,
    input  logic [MARGIN_W-1:0] margin_code,
    output ref_t                target
);
    int m_fac;
    int t_fac;
    int prod;

    always_comb begin
        m_fac  = NOMINAL + margin_offset(margin_code);
        t_fac  = NOMINAL + trim_offset(trim_code);
        prod   = (m_fac * t_fac) / NOMINAL;
        target = REF_W'(prod);
    end
endmodule

// File: rtl/ref_stepper.sv
module ref_stepper
    import ref_slew_pkg::*;
#(
    parameter int STEP = 75
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step_en,
    input  ref_t target,
    output ref_t ref_q
);
    localparam ref_t STEP_V = REF_W'(STEP);

    ref_t gap;
    ref_t nxt;

    always_comb begin
        if (target >= ref_q) begin
            gap = target - ref_q;
            nxt = (gap > STEP_V) ? ref_q + STEP_V : target;
        end else begin
            gap = ref_q - target;
            nxt = (gap > STEP_V) ? ref_q - STEP_V : target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ref_q <= REF_W'(NOMINAL);
        else if (load)    ref_q <= target;
        else if (step_en) ref_q <= nxt;
    end

    // R6
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |->
        ((int'(ref_q) - int'($past(ref_q)) <= STEP) &&
         (int'($past(ref_q)) - int'(ref_q) <= STEP)));

    // R6
    no_overshoot_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(step_en) && !$past(load) &&
         $past(ref_q) <= $past(target)) |-> (ref_q <= $past(target)));

    // R6
    no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(step_en) && !$past(load) &&
         $past(ref_q) >= $past(target)) |-> (ref_q >= $past(target)));
endmodule

// File: rtl/blank_ctrl.sv
module blank_ctrl
    import ref_slew_pkg::*;
#(
    parameter int BLANK_CYC     = 8,
    parameter int TIMEOUT_TICKS = 31
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TRIM_W-1:0]   trim_code,
    input  logic [MARGIN_W-1:0] margin_code,
    input  logic                running,
    input  logic                at_target,
    input  logic                tick,
    input  logic                sw_cycle,
    output logic                slewing,
    output logic                blank
);
    localparam int CYC_W = $clog2(BLANK_CYC + 1);
    localparam int TK_W  = $clog2(TIMEOUT_TICKS + 1);

    blank_state_e        st;
    logic [TRIM_W-1:0]   prev_trim;
    logic [MARGIN_W-1:0] prev_margin;
    logic [CYC_W-1:0]    cyc_cnt;
    logic [TK_W-1:0]     tk_cnt;
    logic                code_chg;
    logic                cyc_done;
    logic                tk_done;

    assign code_chg = (trim_code != prev_trim) || (margin_code != prev_margin);
    assign cyc_done = sw_cycle && (cyc_cnt == CYC_W'(BLANK_CYC - 1));
    assign tk_done  = tick && (tk_cnt == TK_W'(TIMEOUT_TICKS - 1));
    assign slewing  = (st == BL_SLEW);
    assign blank    = (st != BL_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= BL_IDLE;
            prev_trim   <= TRIM_ZERO;
            prev_margin <= MARGIN_ZERO;
            cyc_cnt     <= '0;
            tk_cnt      <= '0;
        end else begin
            prev_trim   <= trim_code;
            prev_margin <= margin_code;
            if (!running) begin
                st      <= BL_IDLE;
                cyc_cnt <= '0;
                tk_cnt  <= '0;
            end else if (code_chg) begin
                st      <= BL_SLEW;
                cyc_cnt <= '0;
                tk_cnt  <= '0;
            end else begin
                case (st)
                    BL_SLEW: if (at_target) st <= BL_SETTLE;
                    BL_SETTLE: begin
                        if (cyc_done || tk_done) begin
                            st      <= BL_IDLE;
                            cyc_cnt <= '0;
                            tk_cnt  <= '0;
                        end else begin
                            if (sw_cycle) cyc_cnt <= cyc_cnt + 1'b1;
                            if (tick)     tk_cnt  <= tk_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12
    stop_clears_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !running |=> !blank);

    // R7
    release_from_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(blank) && $past(running)) |-> ($past(st) == BL_SETTLE));
endmodule

// File: rtl/ref_slew_ctrl.sv
module ref_slew_ctrl
    import ref_slew_pkg::*;
#(
    parameter int STEP          = 75,
    parameter int BLANK_CYC     = 8,
    parameter int TIMEOUT_TICKS = 31
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TRIM_W-1:0]   trim_code,
    input  logic [MARGIN_W-1:0] margin_code,
    input  logic                intload_en,
    input  logic                sw_cycle,
    input  logic                tick,
    input  logic                running,
    output logic [REF_W-1:0]    ref_level,
    output logic                blank,
    output logic                force_dcm,
    output logic                pulldown_en
);
    ref_t target;
    ref_t ref_q;
    logic slewing;
    logic blank_i;

    ref_target_calc u_target (
        .trim_code   (trim_code),
        .margin_code (margin_code),
        .target      (target)
    );

    ref_stepper #(.STEP(STEP)) u_step (
        .clk     (clk),
        .rst     (rst),
        .load    (!running),
        .step_en (slewing && tick),
        .target  (target),
        .ref_q   (ref_q)
    );

    blank_ctrl #(.BLANK_CYC(BLANK_CYC), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_blank (
        .clk         (clk),
        .rst         (rst),
        .trim_code   (trim_code),
        .margin_code (margin_code),
        .running     (running),
        .at_target   (ref_q == target),
        .tick        (tick),
        .sw_cycle    (sw_cycle),
        .slewing     (slewing),
        .blank       (blank_i)
    );

    assign ref_level   = ref_q;
    assign blank       = blank_i;
    assign force_dcm   = blank_i;
    assign pulldown_en = slewing && intload_en && (target < ref_q);

    // R10
    pulldown_down_chk: assert property (@(posedge clk) disable iff (rst)
        pulldown_en |-> (ref_level > target) && blank);

    // R10
    pulldown_gate_chk: assert property (@(posedge clk) disable iff (rst)
        pulldown_en |-> intload_en);
endmodule

// File: tb/ref_slew_ctrl_tb.sv
module ref_slew_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] trim_code;
    logic [2:0] margin_code;
    logic       intload_en;
    logic       sw_cycle;
    logic       tick;
    logic       running;
    logic [13:0] ref_level;
    logic       blank;
    logic       force_dcm;
    logic       pulldown_en;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    ref_slew_ctrl u_dut (
        .clk(clk), .rst(rst), .trim_code(trim_code), .margin_code(margin_code),
        .intload_en(intload_en), .sw_cycle(sw_cycle), .tick(tick), .running(running),
        .ref_level(ref_level), .blank(blank), .force_dcm(force_dcm),
        .pulldown_en(pulldown_en)
    );

    function automatic int exp_target(input int tc, input int mc);
        int t;
        int m;
        if (tc < 4)       t = -900;
        else if (tc < 16) t = (tc - 15) * 75;
        else if (tc < 28) t = (tc - 16) * 75;
        else              t = 900;
        m = (mc == 1) ? -1000 : (mc == 2) ? -500 : (mc == 5) ? 500 : (mc == 6) ? 1000 : 0;
        return ((10000 + m) * (10000 + t)) / 10000;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_sw(input int n);
        for (int i = 0; i < n; i++) begin
            sw_cycle = 1'b1; @(negedge clk); sw_cycle = 1'b0;
        end
    endtask

    task automatic go_nominal();
        running = 1'b0; trim_code = 5'd16; margin_code = 3'd0;
        cyc(2);
        running = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset();
        chk("R13 ref", int'(ref_level), 10000);
        chk("R13 blank", int'(blank), 0);
        chk("R13 dcm", int'(force_dcm), 0);
        chk("R13 pd", int'(pulldown_en), 0);
    endtask

    task automatic t_decode();
        int tl[8] = '{2, 4, 15, 17, 0, 16, 17, 0};
        int ml[8] = '{0, 0, 0, 0, 1, 2, 5, 6};
        running = 1'b0;
        for (int i = 0; i < 8; i++) begin
            trim_code = 5'(tl[i]); margin_code = 3'(ml[i]);
            cyc(1);
            // R1 R2 R3 R4
            chk("R1/R2/R3 target", int'(ref_level), exp_target(tl[i], ml[i]));
            chk("R4 no blank", int'(blank), 0);
        end
        trim_code = 5'd31; margin_code = 3'd6; cyc(1);
        chk("R3 max target", int'(ref_level), 11990);
        margin_code = 3'd3; cyc(1);
        chk("R2 disabled margin", int'(ref_level), 10900);
    endtask

    task automatic t_up_slew();
        go_nominal();
        intload_en = 1'b1;
        trim_code = 5'd28;
        cyc(1);
        chk("R5 blank raised", int'(blank), 1);
        chk("R9 dcm", int'(force_dcm), 1);
        cyc(2);
        chk("R6 no move without tick", int'(ref_level), 10000);
        pulse_tick(11);
        chk("R6 after 11 steps", int'(ref_level), 10825);
        chk("R10 no pd upward", int'(pulldown_en), 0);
        pulse_sw(3);
        pulse_tick(1);
        chk("R6 reached", int'(ref_level), 10900);
        cyc(1);
        pulse_sw(7);
        chk("R7 blank after 7", int'(blank), 1);
        pulse_sw(1);
        chk("R7 blank after 8", int'(blank), 0);
        chk("R9 dcm cleared", int'(force_dcm), 0);
    endtask

    task automatic t_down_timeout();
        intload_en = 1'b1;
        trim_code = 5'd16;
        cyc(1);
        chk("R10 pd downward", int'(pulldown_en), 1);
        pulse_tick(12);
        chk("R6 back to nominal", int'(ref_level), 10000);
        cyc(1);
        chk("R10 pd off in settle", int'(pulldown_en), 0);
        pulse_tick(30);
        chk("R8 blank at 30 ticks", int'(blank), 1);
        pulse_tick(1);
        chk("R8 blank at 31 ticks", int'(blank), 0);
    endtask

    task automatic t_down_noload();
        intload_en = 1'b0;
        trim_code = 5'd0;
        cyc(1);
        pulse_tick(1);
        chk("R10 pd gated", int'(pulldown_en), 0);
        chk("R6 down step", int'(ref_level), 9925);
    endtask

    task automatic t_retarget();
        go_nominal();
        intload_en = 1'b1;
        trim_code = 5'd28;
        cyc(1);
        pulse_tick(3);
        chk("R6 mid slew", int'(ref_level), 10225);
        trim_code = 5'd16;
        cyc(1);
        chk("R11 retarget pd", int'(pulldown_en), 1);
        pulse_tick(1);
        chk("R11 retarget step", int'(ref_level), 10150);
        pulse_tick(2);
        cyc(1);
        pulse_sw(5);
        trim_code = 5'd15;
        cyc(2);
        pulse_sw(7);
        chk("R11 window restarted", int'(blank), 1);
        pulse_sw(1);
        chk("R11 window end", int'(blank), 0);
    endtask

    task automatic t_clamp();
        go_nominal();
        margin_code = 3'd5;
        cyc(1);
        pulse_tick(6);
        chk("R6 six steps", int'(ref_level), 10450);
        pulse_tick(1);
        chk("R6 clamped", int'(ref_level), 10500);
    endtask

    task automatic t_stop();
        go_nominal();
        trim_code = 5'd28;
        cyc(1);
        pulse_tick(2);
        running = 1'b0;
        cyc(1);
        chk("R12 ref loaded", int'(ref_level), 10900);
        chk("R12 blank low", int'(blank), 0);
        running = 1'b1;
        cyc(1);
        chk("R12 no slew on resume", int'(blank), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; trim_code = 5'd16; margin_code = 3'd0;
        intload_en = 1'b0; sw_cycle = 1'b0; tick = 1'b0; running = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_decode();
        t_up_slew();
        t_down_timeout();
        t_down_noload();
        t_retarget();
        t_clamp();
        t_stop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule